// File: doc/BRIEF.md
# Strap latch and clock-stop controller

This block sits between the frequency synthesis of a multi-output clock generator and its output pins. While power is coming up, three pins that later carry clocks are read as configuration straps: a CPU/PCI high-frequency select, an active-low spread-spectrum control and a select for the shared USB/serial clock pin. A power-good input marks the moment the supply has settled. On its first rising edge the strap values are frozen, and one reference-clock cycle later the pins turn around and start driving clocks.

In normal operation the block gates the CPU clock group and the PCI clock group with active-low stop inputs. Every stopped clock parks low. One PCI output does not respond to the PCI stop and keeps running. An active-low power-down input silences every output but keeps the frozen straps. The source clocks (CPU, PCI, 48 MHz and reference) arrive as digital inputs. Each pad is modelled as a separate input, output and output-enable.

Top module: `clkgen_strap_stop`

## Requirements
- R1: Before capture, the strap outputs show the pulled-up default: `strapHfs`=1, `strapSel24`=1, `strapSpreadEn`=0, `strapValid`=0. All three pad enables are 0 and all three pad outputs stay low.
- R2: The straps are captured on the first rising edge of `pwrGood`, which passes through a two-stage synchronizer in the reference domain. `strapValid` is first seen high after the third rising reference edge following the `pwrGood` change. The outputs are set as follows: `strapHfs` = `hfsPadIn`, `strapSel24` = `selPadIn`, and `strapSpreadEn` = NOT `ssPadIn` (a 0 on the pad enables spreading).
- R3: Once captured, the straps stay fixed until `rstN` is asserted. Later changes on the pad inputs, further `pwrGood` edges and power-down do not alter them. A reset restores the R1 defaults.
- R4: All three pad enables rise together exactly one reference cycle after `strapValid` rises, and never before it.
- R5: After turnaround, `hfsPadOut` carries the 48 MHz source when `strapSel24`=0, and half of that rate when `strapSel24`=1. The half-rate clock comes from a toggle flop that is reset low.
- R6: After turnaround, `ssPadOut` and `selPadOut` carry the reference clock.
- R7: While `cpuStopN`=0, every CPU output is parked low within two falling edges of the CPU source. Releasing the stop restores toggling.
- R8: While `pciStopN`=0, every gated PCI output is parked low. `pciFreeClk` keeps toggling.
- R9: While `pwrDownN`=0, every clock output is parked low: CPU, gated PCI, free PCI and the three pads. Releasing it restores toggling.
- R10: Stops and restarts take effect only on a falling edge of the clock being gated, so every high pulse lasts a full high phase of its source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference clock; also the strap-control clock |
| cpuSrcClk | input | 1 | CPU clock source |
| pciSrcClk | input | 1 | PCI clock source |
| usbSrcClk | input | 1 | 48 MHz clock source |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrGood | input | 1 | Supply-settled indication, asynchronous |
| pwrDownN | input | 1 | Active-low power-down of all outputs |
| cpuStopN | input | 1 | Active-low stop for the CPU group |
| pciStopN | input | 1 | Active-low stop for the gated PCI group |
| hfsPadIn | input | 1 | Input side of the high-frequency-select pad |
| ssPadIn | input | 1 | Input side of the spread-control pad |
| selPadIn | input | 1 | Input side of the 48/24 select pad |
| hfsPadOut | output | 1 | 48 or 24 MHz clock onto the select pad |
| hfsPadOe | output | 1 | Drive enable of the select pad |
| ssPadOut | output | 1 | Reference clock onto the spread-control pad |
| ssPadOe | output | 1 | Drive enable of the spread-control pad |
| selPadOut | output | 1 | Reference clock onto the 48/24 select pad |
| selPadOe | output | 1 | Drive enable of the 48/24 select pad |
| strapHfs | output | 1 | Frozen high-frequency select |
| strapSpreadEn | output | 1 | Frozen spread-spectrum enable |
| strapSel24 | output | 1 | Frozen 24 MHz select for the shared pin |
| strapValid | output | 1 | Straps have been captured |
| cpuClkOut | output | NUM_CPU | Gated CPU clocks |
| pciClkOut | output | NUM_PCI | Gated PCI clocks |
| pciFreeClk | output | 1 | Free-running PCI clock |

## Verification
Several rules are checked on every cycle of the relevant domain: the straps stay frozen, the pad enables follow capture by exactly one reference cycle, the pads stay quiet while turned around, and the CPU and PCI groups park low under a stop lasting two falling edges. The free PCI output is also checked to keep running, and power-down is checked to silence the PCI domain. Other behaviour shows only in the bench scenarios, which measure it over sampled windows. These are the strap values seen after capture, the 48 versus 24 MHz rate on the shared pin, the reference clocks on the turned-around pads and the restart after power-down. The scenarios also measure the width of every high pulse across a stop and a restart, which shows that no pulse is cut short.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  // strobes from the strap controller to the datapath
  typedef struct packed {
    logic captureStb;   // latch pad values now
    logic driveStb;     // turn the strap pads into outputs
  } strapCmd_t;

  typedef struct packed {
    logic highFreq;     // CPU/PCI high-frequency select
    logic spreadOff;    // active-low spread control, raw pad level
    logic slowUsb;      // 1 selects half rate on the shared pin
  } strapSet_t;

  localparam strapSet_t STRAP_PULLUP = '{highFreq: 1'b1, spreadOff: 1'b1, slowUsb: 1'b1};

endpackage

// File: rtl/clkstop_gate.sv
// Glitch-free clock gate: enable is resynchronized on falling edges of the
// gated clock, so it only changes while that clock is low.
module clkstop_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic srcClk,
  input  logic rstN,
  input  logic enAsync,
  output logic clkOut
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncQ;

  generate
    if (SYNC_STAGES > 1) begin : gMulti
      always_ff @(negedge srcClk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[LAST-1:0], enAsync};
      end
    end else begin : gSingle
      always_ff @(negedge srcClk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= enAsync;
      end
    end
  endgenerate

  assign clkOut = srcClk & syncQ[LAST];

endmodule

// File: rtl/clkstop_ctrl.sv
// Strap sequencing in the reference domain: detects the first power-good
// rise and issues the capture strobe, then the pad turnaround strobe.
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int PG_SYNC = 2
) (
  input  logic      refClk,
  input  logic      rstN,
  input  logic      pwrGood,
  output strapCmd_t cmd
);

  localparam int LAST = PG_SYNC - 1;

  logic [LAST:0] pgSync;
  logic          pgPrev;
  logic          captured;
  logic          driveQ;
  logic          pgRise;

  assign pgRise = pgSync[LAST] & ~pgPrev & ~captured;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      pgSync   <= '0;
      pgPrev   <= 1'b0;
      captured <= 1'b0;
      driveQ   <= 1'b0;
    end else begin
      pgSync <= {pgSync[LAST-1:0], pwrGood};
      pgPrev <= pgSync[LAST];
      driveQ <= pgRise;
      if (pgRise) captured <= 1'b1;
    end
  end

  assign cmd.captureStb = pgRise;
  assign cmd.driveStb   = driveQ;

endmodule

// File: rtl/clkstop_dpath.sv
// Strap registers, half-rate divider and all output gates.
module clkstop_dpath
  import clkstop_pkg::*;
#(
  parameter int NUM_CPU     = 2,
  parameter int NUM_PCI     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic               refClk,
  input  logic               cpuSrcClk,
  input  logic               pciSrcClk,
  input  logic               usbSrcClk,
  input  logic               rstN,
  input  strapCmd_t          cmd,
  input  logic               pwrDownN,
  input  logic               cpuStopN,
  input  logic               pciStopN,
  input  logic               hfsPadIn,
  input  logic               ssPadIn,
  input  logic               selPadIn,
  output strapSet_t          straps,
  output logic               strapValid,
  output logic               padDrive,
  output logic [NUM_CPU-1:0] cpuClkOut,
  output logic [NUM_PCI-1:0] pciClkOut,
  output logic               pciFreeClk,
  output logic               hfsPadOut,
  output logic               ssPadOut,
  output logic               selPadOut
);

  logic usbHalf;
  logic pinSrc;
  logic cpuEn;
  logic pciEn;
  logic padEn;

  // strap latch: loads once, reset returns the pulled-up default
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      straps     <= STRAP_PULLUP;
      strapValid <= 1'b0;
      padDrive   <= 1'b0;
    end else begin
      if (cmd.captureStb) begin
        straps     <= '{highFreq: hfsPadIn, spreadOff: ssPadIn, slowUsb: selPadIn};
        strapValid <= 1'b1;
      end
      if (cmd.driveStb) padDrive <= 1'b1;
    end
  end

  // divide-by-two, reset low so the first edge out is a rising one
  always_ff @(posedge usbSrcClk or negedge rstN) begin
    if (!rstN) usbHalf <= 1'b0;
    else       usbHalf <= ~usbHalf;
  end

  // select is static once the pad is enabled
  assign pinSrc = straps.slowUsb ? usbHalf : usbSrcClk;

  assign cpuEn = cpuStopN & pwrDownN;
  assign pciEn = pciStopN & pwrDownN;
  assign padEn = padDrive & pwrDownN;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CPU; gi++) begin : gCpu
      clkstop_gate #(.SYNC_STAGES(SYNC_STAGES)) uGate (
        .srcClk (cpuSrcClk),
        .rstN   (rstN),
        .enAsync(cpuEn),
        .clkOut (cpuClkOut[gi])
      );
    end
    for (gi = 0; gi < NUM_PCI; gi++) begin : gPci
      clkstop_gate #(.SYNC_STAGES(SYNC_STAGES)) uGate (
        .srcClk (pciSrcClk),
        .rstN   (rstN),
        .enAsync(pciEn),
        .clkOut (pciClkOut[gi])
      );
    end
  endgenerate

  clkstop_gate #(.SYNC_STAGES(SYNC_STAGES)) uFreeGate (
    .srcClk (pciSrcClk),
    .rstN   (rstN),
    .enAsync(pwrDownN),
    .clkOut (pciFreeClk)
  );

  clkstop_gate #(.SYNC_STAGES(SYNC_STAGES)) uHfsGate (
    .srcClk (pinSrc),
    .rstN   (rstN),
    .enAsync(padEn),
    .clkOut (hfsPadOut)
  );

  clkstop_gate #(.SYNC_STAGES(SYNC_STAGES)) uSsGate (
    .srcClk (refClk),
    .rstN   (rstN),
    .enAsync(padEn),
    .clkOut (ssPadOut)
  );

  clkstop_gate #(.SYNC_STAGES(SYNC_STAGES)) uSelGate (
    .srcClk (refClk),
    .rstN   (rstN),
    .enAsync(padEn),
    .clkOut (selPadOut)
  );

endmodule

// File: rtl/clkgen_strap_stop.sv
module clkgen_strap_stop
  import clkstop_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int NUM_PCI = 5
) (
  input  logic               refClk,
  input  logic               cpuSrcClk,
  input  logic               pciSrcClk,
  input  logic               usbSrcClk,
  input  logic               rstN,
  input  logic               pwrGood,
  input  logic               pwrDownN,
  input  logic               cpuStopN,
  input  logic               pciStopN,
  input  logic               hfsPadIn,
  input  logic               ssPadIn,
  input  logic               selPadIn,
  output logic               hfsPadOut,
  output logic               hfsPadOe,
  output logic               ssPadOut,
  output logic               ssPadOe,
  output logic               selPadOut,
  output logic               selPadOe,
  output logic               strapHfs,
  output logic               strapSpreadEn,
  output logic               strapSel24,
  output logic               strapValid,
  output logic [NUM_CPU-1:0] cpuClkOut,
  output logic [NUM_PCI-1:0] pciClkOut,
  output logic               pciFreeClk
);

  strapCmd_t cmd;
  strapSet_t straps;
  logic      padDrive;

  clkstop_ctrl #(.PG_SYNC(2)) uCtrl (
    .refClk (refClk),
    .rstN   (rstN),
    .pwrGood(pwrGood),
    .cmd    (cmd)
  );

  clkstop_dpath #(
    .NUM_CPU    (NUM_CPU),
    .NUM_PCI    (NUM_PCI),
    .SYNC_STAGES(2)
  ) uDpath (
    .refClk    (refClk),
    .cpuSrcClk (cpuSrcClk),
    .pciSrcClk (pciSrcClk),
    .usbSrcClk (usbSrcClk),
    .rstN      (rstN),
    .cmd       (cmd),
    .pwrDownN  (pwrDownN),
    .cpuStopN  (cpuStopN),
    .pciStopN  (pciStopN),
    .hfsPadIn  (hfsPadIn),
    .ssPadIn   (ssPadIn),
    .selPadIn  (selPadIn),
    .straps    (straps),
    .strapValid(strapValid),
    .padDrive  (padDrive),
    .cpuClkOut (cpuClkOut),
    .pciClkOut (pciClkOut),
    .pciFreeClk(pciFreeClk),
    .hfsPadOut (hfsPadOut),
    .ssPadOut  (ssPadOut),
    .selPadOut (selPadOut)
  );

  assign strapHfs      = straps.highFreq;
  assign strapSpreadEn = ~straps.spreadOff;
  assign strapSel24    = straps.slowUsb;
  assign hfsPadOe      = padDrive;
  assign ssPadOe       = padDrive;
  assign selPadOe      = padDrive;

endmodule

// File: rtl/clkgen_strap_stop_chk.sv
module clkgen_strap_stop_chk #(
  parameter int NUM_CPU = 2,
  parameter int NUM_PCI = 5
) (
  input logic               refClk,
  input logic               cpuSrcClk,
  input logic               pciSrcClk,
  input logic               rstN,
  input logic               pwrDownN,
  input logic               cpuStopN,
  input logic               pciStopN,
  input logic               strapHfs,
  input logic               strapSpreadEn,
  input logic               strapSel24,
  input logic               strapValid,
  input logic               hfsPadOe,
  input logic               ssPadOe,
  input logic               selPadOe,
  input logic               hfsPadOut,
  input logic               ssPadOut,
  input logic               selPadOut,
  input logic [NUM_CPU-1:0] cpuClkOut,
  input logic [NUM_PCI-1:0] pciClkOut,
  input logic               pciFreeClk
);

  AST_STRAP_FROZEN: assert property (@(posedge refClk) disable iff (!rstN)
    (strapValid && $past(strapValid)) |->
      ($stable(strapHfs) && $stable(strapSpreadEn) && $stable(strapSel24))); // R3

  AST_OE_FOLLOWS_VALID: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(strapValid) |=> (hfsPadOe && ssPadOe && selPadOe)); // R4

  AST_OE_NOT_EARLY: assert property (@(posedge refClk) disable iff (!rstN)
    (hfsPadOe || ssPadOe || selPadOe) |-> $past(strapValid)); // R4

  AST_PAD_QUIET: assert property (@(posedge refClk) disable iff (!rstN)
    !hfsPadOe |-> !(hfsPadOut || ssPadOut || selPadOut)); // R1

  AST_CPU_PARKED: assert property (@(negedge cpuSrcClk) disable iff (!rstN)
    (!cpuStopN && $past(!cpuStopN) && $past(!cpuStopN, 2)) |-> (cpuClkOut == '0)); // R7

  AST_PCI_PARKED: assert property (@(negedge pciSrcClk) disable iff (!rstN)
    (!pciStopN && $past(!pciStopN) && $past(!pciStopN, 2)) |-> (pciClkOut == '0)); // R8

  AST_PCI_FREE_RUNS: assert property (@(negedge pciSrcClk) disable iff (!rstN)
    ($past(rstN, 2) && pwrDownN && $past(pwrDownN) && $past(pwrDownN, 2)) |-> pciFreeClk); // R8

  AST_PWRDN_SILENT: assert property (@(negedge pciSrcClk) disable iff (!rstN)
    (!pwrDownN && $past(!pwrDownN) && $past(!pwrDownN, 2)) |->
      (!pciFreeClk && (pciClkOut == '0))); // R9

endmodule

bind clkgen_strap_stop clkgen_strap_stop_chk #(
  .NUM_CPU(NUM_CPU),
  .NUM_PCI(NUM_PCI)
) uChk (.*);

// File: tb/clkgen_strap_stop_test.sv
`timescale 1ns/1ps
module clkgen_strap_stop_test;

  localparam int CLK_PERIOD = 70;   // reference clock
  localparam int CPU_PERIOD = 10;
  localparam int PCI_PERIOD = 30;
  localparam int USB_PERIOD = 20;
  localparam int NUM_CPU = 2;
  localparam int NUM_PCI = 5;
  localparam int NOBS = NUM_CPU + NUM_PCI + 4;
  localparam int IDX_PCI  = NUM_CPU;
  localparam int IDX_FREE = NUM_CPU + NUM_PCI;
  localparam int IDX_HFS  = IDX_FREE + 1;
  localparam int IDX_SS   = IDX_FREE + 2;
  localparam int IDX_SEL  = IDX_FREE + 3;
  localparam int WIN = 400;

  // item kinds
  localparam int K_RISES = 0;
  localparam int K_HIGHS = 1;
  localparam int K_MINRUN = 2;
  localparam int K_LEVEL = 3;

  logic refClk = 0, cpuSrcClk = 0, pciSrcClk = 0, usbSrcClk = 0;
  logic rstN, pwrGood, pwrDownN, cpuStopN, pciStopN;
  logic hfsPadIn, ssPadIn, selPadIn;
  logic hfsPadOut, hfsPadOe, ssPadOut, ssPadOe, selPadOut, selPadOe;
  logic strapHfs, strapSpreadEn, strapSel24, strapValid;
  logic [NUM_CPU-1:0] cpuClkOut;
  logic [NUM_PCI-1:0] pciClkOut;
  logic pciFreeClk;
  logic [NOBS-1:0] obs;

  always #(CLK_PERIOD/2) refClk    = ~refClk;
  always #(CPU_PERIOD/2) cpuSrcClk = ~cpuSrcClk;
  always #(PCI_PERIOD/2) pciSrcClk = ~pciSrcClk;
  always #(USB_PERIOD/2) usbSrcClk = ~usbSrcClk;

  clkgen_strap_stop #(.NUM_CPU(NUM_CPU), .NUM_PCI(NUM_PCI)) uut (
    .refClk(refClk), .cpuSrcClk(cpuSrcClk), .pciSrcClk(pciSrcClk), .usbSrcClk(usbSrcClk),
    .rstN(rstN), .pwrGood(pwrGood), .pwrDownN(pwrDownN), .cpuStopN(cpuStopN),
    .pciStopN(pciStopN), .hfsPadIn(hfsPadIn), .ssPadIn(ssPadIn), .selPadIn(selPadIn),
    .hfsPadOut(hfsPadOut), .hfsPadOe(hfsPadOe), .ssPadOut(ssPadOut), .ssPadOe(ssPadOe),
    .selPadOut(selPadOut), .selPadOe(selPadOe), .strapHfs(strapHfs),
    .strapSpreadEn(strapSpreadEn), .strapSel24(strapSel24), .strapValid(strapValid),
    .cpuClkOut(cpuClkOut), .pciClkOut(pciClkOut), .pciFreeClk(pciFreeClk)
  );

  assign obs = {selPadOut, ssPadOut, hfsPadOut, pciFreeClk, pciClkOut, cpuClkOut};

  // window metrics, written only by the driver
  int rises[NOBS];
  int highs[NOBS];
  int minRun[NOBS];
  int capIdx, oeGap;

  typedef struct {
    string tag;
    int    kind;
    int    sel;
    int    lo;
    int    hi;
  } item_t;

  item_t expQ[$];
  event  itemEv;
  int    checks = 0;
  int    failures = 0;
  bit    finished = 0;

  function automatic int levelOf(input int sel);
    case (sel)
      0: return int'(strapHfs);
      1: return int'(strapSpreadEn);
      2: return int'(strapSel24);
      3: return int'(strapValid);
      4: return int'(hfsPadOe);
      5: return int'(ssPadOe);
      6: return int'(selPadOe);
      7: return capIdx;
      default: return oeGap;
    endcase
  endfunction

  function automatic int actualOf(input item_t it);
    case (it.kind)
      K_RISES:  return rises[it.sel];
      K_HIGHS:  return highs[it.sel];
      K_MINRUN: return minRun[it.sel];
      default:  return levelOf(it.sel);
    endcase
  endfunction

  // monitor: pops expected items and compares with what the design produced
  initial begin
    forever begin
      @(itemEv);
      while (expQ.size() > 0) begin
        item_t it;
        int act;
        it = expQ.pop_front();
        act = actualOf(it);
        checks++;
        if (act < it.lo || act > it.hi) begin
          failures++;
          $display("FAIL %s actual=%0d expected=%0d..%0d", it.tag, act, it.lo, it.hi);
        end
      end
    end
  end

  task automatic expectItem(input string tag, input int kind, input int sel,
                            input int lo, input int hi);
    item_t it;
    it.tag = tag; it.kind = kind; it.sel = sel; it.lo = lo; it.hi = hi;
    expQ.push_back(it);
  endtask

  task automatic flushItems();
    -> itemEv;
    #1;
  endtask

  // samples all outputs every 1 ns at half-ns offsets; optionally flips cpuStopN
  task automatic sampleWindow(input int nSamples, input int flipAt);
    logic [NOBS-1:0] prev;
    int run[NOBS];
    bit inRun[NOBS];
    for (int b = 0; b < NOBS; b++) begin
      rises[b] = 0; highs[b] = 0; minRun[b] = 1000; run[b] = 0; inRun[b] = 0;
    end
    #0.5;
    prev = obs;
    for (int s = 0; s < nSamples; s++) begin
      if (s == flipAt) cpuStopN = ~cpuStopN;
      #1;
      for (int b = 0; b < NOBS; b++) begin
        if (obs[b]) highs[b]++;
        if (obs[b] && !prev[b]) begin
          rises[b]++;
          inRun[b] = 1;
          run[b] = 1;
        end else if (obs[b] && inRun[b]) begin
          run[b]++;
        end else if (!obs[b] && prev[b] && inRun[b]) begin
          if (run[b] < minRun[b]) minRun[b] = run[b];
          inRun[b] = 0;
        end
      end
      prev = obs;
    end
    #0.5;
  endtask

  task automatic measureCapture();
    int vIdx, oIdx;
    vIdx = -1; oIdx = -1;
    @(negedge refClk);
    pwrGood = 1'b1;
    for (int c = 0; c < 8; c++) begin
      @(negedge refClk);
      #1;
      if (strapValid && vIdx < 0) vIdx = c;
      if (hfsPadOe && oIdx < 0) oIdx = c;
    end
    capIdx = vIdx;
    oeGap = oIdx - vIdx;
  endtask

  task automatic printSummary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog R9 actual=timeout expected=completion");
      printSummary();
      $finish;
    end
  end

  // driver
  initial begin
    rstN = 0; pwrGood = 0; pwrDownN = 1; cpuStopN = 1; pciStopN = 1;
    hfsPadIn = 0; ssPadIn = 0; selPadIn = 0;
    #203;
    rstN = 1;
    #300;

    // R1: defaults before capture
    expectItem("R1 strapHfs default", K_LEVEL, 0, 1, 1);
    expectItem("R1 strapSpreadEn default", K_LEVEL, 1, 0, 0);
    expectItem("R1 strapSel24 default", K_LEVEL, 2, 1, 1);
    expectItem("R1 strapValid low", K_LEVEL, 3, 0, 0);
    expectItem("R1 hfsPadOe low", K_LEVEL, 4, 0, 0);
    expectItem("R1 ssPadOe low", K_LEVEL, 5, 0, 0);
    expectItem("R1 selPadOe low", K_LEVEL, 6, 0, 0);
    flushItems();
    sampleWindow(WIN, -1);
    expectItem("R1 hfsPadOut quiet", K_HIGHS, IDX_HFS, 0, 0);
    expectItem("R1 ssPadOut quiet", K_HIGHS, IDX_SS, 0, 0);
    expectItem("R1 selPadOut quiet", K_HIGHS, IDX_SEL, 0, 0);
    expectItem("R7 cpu0 runs at start", K_RISES, 0, 39, 41);
    expectItem("R8 free PCI runs at start", K_RISES, IDX_FREE, 12, 14);
    flushItems();

    // R2 / R4: capture timing and values
    measureCapture();
    expectItem("R2 capture latency", K_LEVEL, 7, 2, 2);
    expectItem("R4 enable gap", K_LEVEL, 8, 1, 1);
    expectItem("R2 strapHfs captured 0", K_LEVEL, 0, 0, 0);
    expectItem("R2 strapSpreadEn from pad 0", K_LEVEL, 1, 1, 1);
    expectItem("R2 strapSel24 captured 0", K_LEVEL, 2, 0, 0);
    expectItem("R4 ssPadOe high", K_LEVEL, 5, 1, 1);
    expectItem("R4 selPadOe high", K_LEVEL, 6, 1, 1);
    flushItems();

    // R3: pad changes and further power-good edges are ignored
    hfsPadIn = 1; ssPadIn = 1; selPadIn = 1;
    @(negedge refClk);
    pwrGood = 1'b0;
    repeat (4) @(negedge refClk);
    pwrGood = 1'b1;
    repeat (6) @(negedge refClk);
    #1;
    expectItem("R3 strapHfs frozen", K_LEVEL, 0, 0, 0);
    expectItem("R3 strapSpreadEn frozen", K_LEVEL, 1, 1, 1);
    expectItem("R3 strapSel24 frozen", K_LEVEL, 2, 0, 0);
    flushItems();

    // R5 / R6: turned-around pads carry clocks
    sampleWindow(WIN, -1);
    expectItem("R5 hfs pad at 48", K_RISES, IDX_HFS, 19, 21);
    expectItem("R6 ss pad reference", K_RISES, IDX_SS, 5, 6);
    expectItem("R6 sel pad reference", K_RISES, IDX_SEL, 5, 6);
    for (int i = 0; i < NUM_PCI; i++)
      expectItem("R8 gated PCI runs", K_RISES, IDX_PCI + i, 12, 14);
    flushItems();

    // R10 / R7: stop CPU mid-window, then hold
    sampleWindow(WIN, WIN / 2);
    for (int i = 0; i < NUM_CPU; i++)
      expectItem("R10 cpu pulses full width at stop", K_MINRUN, i, 5, 5);
    flushItems();
    #100;
    sampleWindow(WIN, -1);
    for (int i = 0; i < NUM_CPU; i++)
      expectItem("R7 cpu parked low", K_HIGHS, i, 0, 0);
    expectItem("R7 PCI unaffected by CPU stop", K_RISES, IDX_PCI, 12, 14);
    flushItems();
    sampleWindow(WIN, WIN / 2);
    for (int i = 0; i < NUM_CPU; i++)
      expectItem("R10 cpu pulses full width at restart", K_MINRUN, i, 5, 5);
    flushItems();
    #100;
    sampleWindow(WIN, -1);
    for (int i = 0; i < NUM_CPU; i++)
      expectItem("R7 cpu resumes", K_RISES, i, 39, 41);
    flushItems();

    // R8: PCI stop
    pciStopN = 0;
    #100;
    sampleWindow(WIN, -1);
    for (int i = 0; i < NUM_PCI; i++)
      expectItem("R8 gated PCI parked", K_HIGHS, IDX_PCI + i, 0, 0);
    expectItem("R8 free PCI keeps running", K_RISES, IDX_FREE, 12, 14);
    expectItem("R8 cpu unaffected by PCI stop", K_RISES, 0, 39, 41);
    flushItems();
    pciStopN = 1;

    // R9: power-down
    pwrDownN = 0;
    #200;
    sampleWindow(WIN, -1);
    expectItem("R9 cpu0 parked", K_HIGHS, 0, 0, 0);
    expectItem("R9 pci0 parked", K_HIGHS, IDX_PCI, 0, 0);
    expectItem("R9 free PCI parked", K_HIGHS, IDX_FREE, 0, 0);
    expectItem("R9 hfs pad parked", K_HIGHS, IDX_HFS, 0, 0);
    expectItem("R9 ss pad parked", K_HIGHS, IDX_SS, 0, 0);
    expectItem("R9 sel pad parked", K_HIGHS, IDX_SEL, 0, 0);
    expectItem("R3 strapSpreadEn kept in power-down", K_LEVEL, 1, 1, 1);
    expectItem("R3 strapValid kept in power-down", K_LEVEL, 3, 1, 1);
    flushItems();
    pwrDownN = 1;
    #300;
    sampleWindow(WIN, -1);
    expectItem("R9 hfs pad restarts", K_RISES, IDX_HFS, 19, 21);
    expectItem("R9 free PCI restarts", K_RISES, IDX_FREE, 12, 14);
    expectItem("R9 cpu restarts", K_RISES, 0, 39, 41);
    flushItems();

    // second power-up: all straps high, half rate on the shared pin
    rstN = 0;
    pwrGood = 0;
    #100;
    expectItem("R3 reset restores strapSel24", K_LEVEL, 2, 1, 1);
    expectItem("R3 reset restores strapValid", K_LEVEL, 3, 0, 0);
    flushItems();
    hfsPadIn = 1; ssPadIn = 1; selPadIn = 1;
    @(negedge refClk);
    #3;
    rstN = 1;
    #200;
    measureCapture();
    expectItem("R2 strapHfs captured 1", K_LEVEL, 0, 1, 1);
    expectItem("R2 strapSpreadEn off for pad 1", K_LEVEL, 1, 0, 0);
    expectItem("R2 strapSel24 captured 1", K_LEVEL, 2, 1, 1);
    expectItem("R4 enable gap second run", K_LEVEL, 8, 1, 1);
    flushItems();
    #200;
    sampleWindow(WIN, -1);
    expectItem("R5 hfs pad at 24", K_RISES, IDX_HFS, 9, 11);
    expectItem("R6 ss pad reference second run", K_RISES, IDX_SS, 5, 6);
    flushItems();

    #10;
    finished = 1;
    printSummary();
    $finish;
  end

endmodule